// File: doc/BRIEF.md
# Dual-Group GPIO Bank with Edge and Level Interrupts

This block is a register-mapped general-purpose I/O bank. It serves up to 64 pins, split into groups of 32. Every group holds its own copy of eight 32-bit registers:

- pin output value
- output disable
- blink select
- input inversion
- input readback
- latched edge flags
- edge interrupt enable
- level interrupt enable

Software reaches these registers over a plain 32-bit write port and a combinational read port. The block drives pad output values and pad enables. It synchronises the pad inputs through two flops and applies a per-pin inversion before anything else uses the input.

Each pin can raise an interrupt in two ways. The first is a latched rising edge of its inverted-and-synchronised input, gated by an edge enable. The second is the present level of that same input, gated by a level enable. Pending sources are ORed into one request line per slice of eight pins. Flags are acknowledged pin by pin by writing a 0 to the flag bit. A per-pin blink select replaces the driven value with a square wave from a shared divider. The register port always accepts a write in the cycle it is presented, so there is no back-pressure and no handshake on any pin.

Top module: `gpio_bank`

## Requirements
- R1: Register address bit 3 selects the group (0 = pins 0..31, 1 = pins 32..63), and bit k of a group register belongs to pin 32*group+k. Address bits 2:0 select the register: 0 output value, 1 output disable, 2 blink select, 3 input inversion, 4 input readback, 5 edge flags, 6 edge enable, 7 level enable.
- R2: The input readback bit of a pin equals its pad level, delayed by two clock edges, XOR its inversion bit.
- R3: An output disable bit of 0 makes `pin_oe` high and drives `pin_out` with the pin's output value. A bit of 1 leaves `pin_oe` low.
- R4: When a pin's blink bit is 1, `pin_out` follows a square wave with a 50% duty cycle: BLINK_HALF cycles high, then BLINK_HALF cycles low.
- R5: An edge flag bit is set on a 0-to-1 change of the pin's inverted-and-synchronised input, whatever the enable settings.
- R6: A write to the edge flag register clears each flag bit written as 0 and leaves each flag bit written as 1 unchanged.
- R7: `irq[j]` is high while any pin 8j..8j+7 has both its edge flag and its edge enable set.
- R8: `irq[j]` is high while any pin 8j..8j+7 has both its input readback bit and its level enable set. Changing only the inversion bit can therefore raise or drop the line.
- R9: After reset, the following are 0: all enables, all edge flags, output values, blink bits, inversion bits and `irq`. All output disable bits are 1.
- R10: Writes to the input readback address change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Write strobe, taken on the rising clock edge |
| reg_addr | input | 4 | {group, register select} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pin_in | input | 64 | Pad input levels, asynchronous |
| pin_out | output | 64 | Pad output values |
| pin_oe | output | 64 | Pad output enables, active high |
| irq | output | 8 | Interrupt requests, one per eight pins |

## Verification
The hardest case to reach from the ports is a level request that changes with no pad movement at all. The stimulus enables level detection on a low pin, then flips only that pin's inversion bit. The request must appear. Driving the pad high must then withdraw it again.

A second delicate case is the acknowledge. Two flags in the same slice are raised, and one is cleared with a write that keeps the other. The test checks that the readback keeps exactly the surviving flag and that the request line follows the enable of the cleared pin.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int GROUP_W   = 32;
  localparam int REG_SEL_W = 3;

  typedef enum logic [REG_SEL_W-1:0] {
    SEL_DOUT  = 3'd0,
    SEL_ODIS  = 3'd1,
    SEL_BLINK = 3'd2,
    SEL_INV   = 3'd3,
    SEL_DIN   = 3'd4,
    SEL_FLAG  = 3'd5,
    SEL_EEN   = 3'd6,
    SEL_LEN   = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_blink_div.sv
module gpio_blink_div #(
  parameter int BLINK_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase
);
  localparam int CNT_W = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLINK_HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase = phase_q;

  // The wave may only flip after a full half period has been counted.
  assert_blink_cadence_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_q) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/gpio_group.sv
module gpio_group
  import gpio_bank_pkg::*;
#(
  parameter int IRQ_SLICE = 8,
  localparam int NUM_IRQ  = GROUP_W / IRQ_SLICE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  reg_sel_e           sel,
  input  logic [GROUP_W-1:0] wr_data,
  input  logic [GROUP_W-1:0] pad_sync,
  input  logic               blink_phase,
  output logic [GROUP_W-1:0] rd_data,
  output logic [GROUP_W-1:0] pin_out,
  output logic [GROUP_W-1:0] pin_oe,
  output logic [NUM_IRQ-1:0] irq
);
  logic [GROUP_W-1:0] dout_q, odis_q, blink_q, inv_q;
  logic [GROUP_W-1:0] een_q, len_q, flag_q, prev_q;
  logic [GROUP_W-1:0] adj, rise, pend;

  assign adj  = pad_sync ^ inv_q;
  assign rise = adj & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      odis_q  <= '1;
      blink_q <= '0;
      inv_q   <= '0;
      een_q   <= '0;
      len_q   <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_DOUT:  dout_q  <= wr_data;
        SEL_ODIS:  odis_q  <= wr_data;
        SEL_BLINK: blink_q <= wr_data;
        SEL_INV:   inv_q   <= wr_data;
        SEL_EEN:   een_q   <= wr_data;
        SEL_LEN:   len_q   <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= adj;
      if (wr_en && sel == SEL_FLAG) flag_q <= (flag_q & wr_data) | rise;
      else                          flag_q <= flag_q | rise;
    end
  end

  always_comb begin
    case (sel)
      SEL_DOUT:  rd_data = dout_q;
      SEL_ODIS:  rd_data = odis_q;
      SEL_BLINK: rd_data = blink_q;
      SEL_INV:   rd_data = inv_q;
      SEL_DIN:   rd_data = adj;
      SEL_FLAG:  rd_data = flag_q;
      SEL_EEN:   rd_data = een_q;
      default:   rd_data = len_q;
    endcase
  end

  assign pend = (flag_q & een_q) | (adj & len_q);

  for (genvar p = 0; p < GROUP_W; p++) begin : g_pin
    assign pin_out[p] = blink_q[p] ? blink_phase : dout_q[p];
    assign pin_oe[p]  = ~odis_q[p];
  end

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
    assign irq[k] = |pend[k*IRQ_SLICE +: IRQ_SLICE];
  end

  // A flag may only appear where a rising edge was seen one cycle earlier.
  assert_flag_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q) & ~$past(rise)) == '0));

  // After an acknowledge, bits written as 0 are gone unless a new edge arrived.
  assert_flag_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_FLAG) |=> ((flag_q & ~$past(wr_data) & ~$past(rise)) == '0));

  // Leaving reset, no interrupt source is enabled or latched.
  assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (een_q == '0 && len_q == '0 && flag_q == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int IRQ_SLICE  = 8,
  parameter int BLINK_HALF = 4,
  localparam int GRP_SEL_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int ADDR_W    = REG_SEL_W + GRP_SEL_W,
  localparam int NUM_PINS  = NUM_GROUPS * GROUP_W,
  localparam int IRQ_PER_G = GROUP_W / IRQ_SLICE,
  localparam int NUM_IRQ   = NUM_GROUPS * IRQ_PER_G
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wen,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [GROUP_W-1:0]  reg_wdata,
  output logic [GROUP_W-1:0]  reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_IRQ-1:0]  irq
);
  logic [NUM_PINS-1:0]  pad_sync;
  logic                 blink_phase;
  logic [GRP_SEL_W-1:0] grp;
  reg_sel_e             sel;
  logic [GROUP_W-1:0]   grp_rd [NUM_GROUPS];

  assign grp = reg_addr[ADDR_W-1:REG_SEL_W];
  assign sel = reg_sel_e'(reg_addr[REG_SEL_W-1:0]);

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pad_sync)
  );

  gpio_blink_div #(.BLINK_HALF(BLINK_HALF)) u_blink (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (blink_phase)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    gpio_group #(.IRQ_SLICE(IRQ_SLICE)) u_group (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (reg_wen && (int'(grp) == g)),
      .sel         (sel),
      .wr_data     (reg_wdata),
      .pad_sync    (pad_sync[g*GROUP_W +: GROUP_W]),
      .blink_phase (blink_phase),
      .rd_data     (grp_rd[g]),
      .pin_out     (pin_out[g*GROUP_W +: GROUP_W]),
      .pin_oe      (pin_oe[g*GROUP_W +: GROUP_W]),
      .irq         (irq[g*IRQ_PER_G +: IRQ_PER_G])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (int'(grp) == g) reg_rdata = grp_rd[g];
    end
  end
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] pin_in = '0;
  logic [63:0] pin_out, pin_oe;
  logic [7:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  gpio_bank #(.NUM_GROUPS(2), .IRQ_SLICE(8), .BLINK_HALF(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Input patterns and inversion masks; readback must be their XOR (R2).
  localparam logic [63:0] VEC_PINS [6] = '{
    64'h0000_0000_0000_0001, 64'hFFFF_FFFF_0000_0000, 64'h1234_5678_9ABC_DEF0,
    64'h0000_0000_0000_0000, 64'h8000_0001_8000_0001, 64'hDEAD_BEEF_0F0F_F0F0};
  localparam logic [63:0] VEC_INV [6] = '{
    64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 64'hFFFF_0000_0000_FFFF,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 64'h0F0F_0F0F_AAAA_5555};

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int highs;
    bit held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset values of every register and output
    for (int g = 0; g < 2; g++) begin
      for (int s = 0; s < 8; s++) begin
        if (s == 4) continue;
        rd(4'(g*8 + s), v);
        check("R9 reset reg", 64'(v), (s == 1) ? 64'hFFFF_FFFF : 64'h0);
      end
    end
    check("R9 reset irq", 64'(irq), 64'h0);
    check("R9 reset oe", pin_oe, 64'h0);

    // R1/R2: walk the vector table
    for (int i = 0; i < 6; i++) begin
      logic [31:0] lo, hi;
      wr(4'h3, VEC_INV[i][31:0]);
      wr(4'hB, VEC_INV[i][63:32]);
      @(negedge clk);
      pin_in = VEC_PINS[i];
      settle();
      rd(4'h4, lo);
      rd(4'hC, hi);
      check("R2 readback low",  64'(lo), 64'(VEC_PINS[i][31:0]  ^ VEC_INV[i][31:0]));
      check("R1 readback high", 64'(hi), 64'(VEC_PINS[i][63:32] ^ VEC_INV[i][63:32]));
    end

    // R10: writes to the readback address are ignored
    rd(4'h4, v);
    wr(4'h4, ~v);
    wr(4'hC, 32'hFFFF_FFFF);
    begin
      logic [31:0] lo;
      rd(4'h4, lo);
      check("R10 readback unchanged", 64'(lo), 64'(VEC_PINS[5][31:0] ^ VEC_INV[5][31:0]));
    end

    // Back to a quiet state
    wr(4'h3, 32'h0); wr(4'hB, 32'h0);
    @(negedge clk); pin_in = '0;
    settle();
    wr(4'h5, 32'h0); wr(4'hD, 32'h0);
    rd(4'hD, v);
    check("R6 clear all flags", 64'(v), 64'h0);

    // R3: drive pins 0..7 and pin 32
    wr(4'h0, 32'h0000_00A5);
    wr(4'h1, 32'hFFFF_FF00);
    wr(4'h8, 32'h0000_0001);
    wr(4'h9, 32'hFFFF_FFFE);
    @(negedge clk);
    check("R3 driven values", 64'(pin_out[7:0]), 64'hA5);
    check("R3 enables low group", 64'(pin_oe[31:0]), 64'h0000_00FF);
    check("R1 high group pin32 out", 64'({pin_out[32], pin_oe[32], pin_oe[33]}), 64'b110);

    // R4: blink pin 1 (value 0), pin 0 stays held at 1
    wr(4'h2, 32'h0000_0002);
    highs = 0; held = 1'b1;
    for (int c = 0; c < 4*HALF; c++) begin
      @(negedge clk);
      if (pin_out[1]) highs++;
      if (!pin_out[0]) held = 1'b0;
    end
    check("R4 blink duty", 64'(highs), 64'(2*HALF));
    check("R4 non-blink pin held", 64'(held), 64'h1);
    wr(4'h2, 32'h0);

    // R5: rising edge on pin 40 latches with enables off
    @(negedge clk); pin_in[40] = 1'b1; pin_in[41] = 1'b1;
    settle();
    rd(4'hD, v);
    check("R5 flag latched unmasked", 64'(v), 64'h0000_0300);
    check("R5 no irq while disabled", 64'(irq), 64'h0);

    // R7: enabling pin 40 edge raises irq[5]
    wr(4'hE, 32'h0000_0100);
    @(negedge clk);
    check("R7 edge irq", 64'(irq), 64'h20);

    // R6: acknowledge pin 40 only; pin 41 flag survives
    wr(4'hD, 32'hFFFF_FEFF);
    rd(4'hD, v);
    check("R6 selective ack", 64'(v), 64'h0000_0200);
    check("R7 irq drops after ack", 64'(irq), 64'h0);
    wr(4'hE, 32'h0);

    // R8: level request from inversion alone on pin 20
    wr(4'h7, 32'h0010_0000);
    settle();
    check("R8 no level irq while low", 64'(irq), 64'h0);
    wr(4'h3, 32'h0010_0000);
    settle();
    check("R8 inversion raises level irq", 64'(irq), 64'h04);
    @(negedge clk); pin_in[20] = 1'b1;
    settle();
    check("R8 pad high drops level irq", 64'(irq), 64'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule